// File: doc/BRIEF.md
# Capture Event Status and Interrupt Controller

This block holds the event flags of a video capture unit and turns them into one level-sensitive interrupt request. The capture engine sends single-cycle pulses when a frame has been fully flushed to memory and when its internal buffer overflows. The block also watches the current line number against a programmable line threshold and raises a flag the first time the two match. Each event has a sticky status flag, an interrupt enable bit and a write-1-to-acknowledge bit.

Software writes one control word through a single write strobe. The low bits of that word load the interrupt enables, and the high bits acknowledge flags. Acknowledging the capture-complete flag does more than clear it. It also sends a one-cycle pulse back to the capture engine, which starts the next frame.

A field-2 indicator from the capture engine is sampled into status only at the start of vertical blanking, so software sees which field the last frame was. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `vcap_irq_ctrl`

## Requirements
- R1: While rst_n is low, stat_flags, stat_field2, irq and next_frame_go are all 0, and the interrupt enables are cleared.
- R2: A cycle with cap_done high sets stat_flags[0] at the next clock edge. A cycle with ovf_err high sets stat_flags[2] at the next clock edge. A set flag stays set until it is acknowledged.
- R3: stat_flags[1] is set at the clock edge that ends the first cycle in which line_cnt equals line_thresh after a cycle in which they differed. Staying equal sets the flag no more than once, even after an acknowledge.
- R4: Every flag sets whatever the interrupt enables hold. This includes the threshold flag while all enables are 0.
- R5: A cycle with ctl_wr high and ctl_wdata[3+i] = 1 clears stat_flags[i] at the next edge. Acknowledge bits written as 0 have no effect. Several flags may be cleared in one write.
- R6: When the event and its acknowledge occur in the same cycle, the flag is set after the edge.
- R7: A write with ctl_wdata[3] = 1 makes next_frame_go high for exactly the following cycle, even if the event wins in that cycle. Otherwise next_frame_go is low.
- R8: irq is high exactly while some stat_flags[i] is 1 and its enable is 1. It falls at the same clock edge that clears the last enabled flag.
- R9: Every ctl_wr cycle loads the enables from ctl_wdata[2:0]. Bit i enables event i, where 0 is capture complete, 1 is threshold and 2 is overflow.
- R10: stat_field2 takes the value of field2_in at the edge that ends a cycle with vblank_start high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_done | input | 1 | Pulse: frame fully flushed to memory |
| ovf_err | input | 1 | Pulse: internal buffer overflow |
| line_cnt | input | LINE_W | Current line number |
| line_thresh | input | LINE_W | Programmed line threshold |
| field2_in | input | 1 | Field indication from capture engine |
| vblank_start | input | 1 | Pulse at the start of vertical blanking |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | [2:0] enables, [5:3] acknowledges |
| stat_flags | output | 3 | Sticky flags: [0] done, [1] threshold, [2] overflow |
| stat_field2 | output | 1 | Latched field-2 indicator |
| irq | output | 1 | Level-sensitive interrupt request |
| next_frame_go | output | 1 | One-cycle pulse releasing the next frame capture |

## Verification
All state of this block is visible at the ports. A flag that is stuck or lost shows up in stat_flags on the cycle after the event or acknowledge. A wrong enable register shows up on irq in the same cycle, as soon as any flag is set. A bad threshold edge detector shows up as a missing or repeated threshold flag one cycle after line_cnt reaches line_thresh. The bench's reference model is compared against every output on every clock, so any of these faults is reported within one cycle of the moment it first matters.

// File: rtl/vcap_irq_pkg.sv
package vcap_irq_pkg;
  localparam int NUM_EV    = 3;
  localparam int EV_DONE   = 0;
  localparam int EV_THRESH = 1;
  localparam int EV_OVF    = 2;
  localparam int CTL_W     = 2 * NUM_EV;
  localparam int ACK_LSB   = NUM_EV;
  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/vcap_thresh_detect.sv
module vcap_thresh_detect #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [LINE_W-1:0] line_thresh,
  output logic              hit_pulse
);
  logic match_now;
  logic match_q;

  assign match_now = (line_cnt == line_thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_now;
  end

  // rising edge of the compare: one pulse per arrival at the threshold
  assign hit_pulse = match_now & ~match_q;
endmodule

// File: rtl/vcap_event_flag.sv
module vcap_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // event has priority over acknowledge
    else if (ack_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/vcap_ctl_decode.sv
module vcap_ctl_decode
  import vcap_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output ev_vec_t          en_q,
  output ev_vec_t          ack_vec,
  output logic             go_q
);
  assign ack_vec = ctl_wr ? ctl_wdata[CTL_W-1:ACK_LSB] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      go_q <= 1'b0;
    end else begin
      if (ctl_wr) en_q <= ctl_wdata[NUM_EV-1:0];
      go_q <= ack_vec[EV_DONE];
    end
  end
endmodule

// File: rtl/vcap_field_track.sv
module vcap_field_track (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank_start,
  input  logic field2_in,
  output logic field2_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            field2_q <= 1'b0;
    else if (vblank_start) field2_q <= field2_in;
  end
endmodule

// File: rtl/vcap_irq_ctrl.sv
module vcap_irq_ctrl
  import vcap_irq_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_done,
  input  logic              ovf_err,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [LINE_W-1:0] line_thresh,
  input  logic              field2_in,
  input  logic              vblank_start,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [NUM_EV-1:0] stat_flags,
  output logic              stat_field2,
  output logic              irq,
  output logic              next_frame_go
);
  ev_vec_t ev_set;
  ev_vec_t ev_ack;
  ev_vec_t ev_en;
  logic    thresh_hit;

  vcap_thresh_detect #(.LINE_W(LINE_W)) u_thresh (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_cnt    (line_cnt),
    .line_thresh (line_thresh),
    .hit_pulse   (thresh_hit)
  );

  vcap_ctl_decode u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .en_q      (ev_en),
    .ack_vec   (ev_ack),
    .go_q      (next_frame_go)
  );

  vcap_field_track u_field (
    .clk          (clk),
    .rst_n        (rst_n),
    .vblank_start (vblank_start),
    .field2_in    (field2_in),
    .field2_q     (stat_field2)
  );

  always_comb begin
    ev_set            = '0;
    ev_set[EV_DONE]   = cap_done;
    ev_set[EV_THRESH] = thresh_hit;
    ev_set[EV_OVF]    = ovf_err;
  end

  for (genvar gi = 0; gi < NUM_EV; gi++) begin : g_flag
    vcap_event_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (ev_set[gi]),
      .ack_i  (ev_ack[gi]),
      .flag_o (stat_flags[gi])
    );
  end

  // level request straight from registered state: drops on the clearing edge
  assign irq = |(stat_flags & ev_en);
endmodule

// File: rtl/vcap_irq_chk.sv
module vcap_irq_chk
  import vcap_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cap_done,
  input logic              ovf_err,
  input logic              vblank_start,
  input logic              ctl_wr,
  input logic [CTL_W-1:0]  ctl_wdata,
  input logic [NUM_EV-1:0] stat_flags,
  input logic              stat_field2,
  input logic              irq,
  input logic              next_frame_go
);
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n) cap_done |=> stat_flags[EV_DONE]); // R2
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n) ovf_err |=> stat_flags[EV_OVF]); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (stat_flags != '0)); // R8
  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (ctl_wr && ctl_wdata[NUM_EV-1:0] == '0) |=> !irq); // R9
  AST_GO_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) (ctl_wr && ctl_wdata[ACK_LSB+EV_DONE]) |=> next_frame_go); // R7
  AST_GO_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n) !ctl_wr |=> !next_frame_go); // R7
  AST_FIELD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !vblank_start |=> $stable(stat_field2)); // R10
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ctl_wr && ctl_wdata[ACK_LSB+EV_DONE] && !cap_done) |=> !stat_flags[EV_DONE]); // R5

  for (genvar gi = 0; gi < NUM_EV; gi++) begin : g_keep
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (stat_flags[gi] && !(ctl_wr && ctl_wdata[ACK_LSB+gi])) |=> stat_flags[gi]); // R5
  end
endmodule

bind vcap_irq_ctrl vcap_irq_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cap_done      (cap_done),
  .ovf_err       (ovf_err),
  .vblank_start  (vblank_start),
  .ctl_wr        (ctl_wr),
  .ctl_wdata     (ctl_wdata),
  .stat_flags    (stat_flags),
  .stat_field2   (stat_field2),
  .irq           (irq),
  .next_frame_go (next_frame_go)
);

// File: tb/test_vcap_irq_ctrl.sv
`timescale 1ns/1ps
module test_vcap_irq_ctrl;
  localparam int LW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cap_done = 1'b0, ovf_err = 1'b0;
  logic [LW-1:0] line_cnt = '0, line_thresh = 11'd5;
  logic          field2_in = 1'b0, vblank_start = 1'b0;
  logic          ctl_wr = 1'b0;
  logic [5:0]    ctl_wdata = '0;
  logic [2:0]    stat_flags;
  logic          stat_field2, irq, next_frame_go;

  int    n_checks = 0;
  int    n_errors = 0;
  int    cyc = 0;
  string cur_req = "R1";

  // reference model state
  bit [2:0] m_fl = 0;
  bit [2:0] m_en = 0;
  bit       m_go = 0, m_f2 = 0, m_prev = 0;

  vcap_irq_ctrl #(.LINE_W(LW)) i_vcap_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cap_done(cap_done), .ovf_err(ovf_err),
    .line_cnt(line_cnt), .line_thresh(line_thresh), .field2_in(field2_in),
    .vblank_start(vblank_start), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .stat_flags(stat_flags), .stat_field2(stat_field2), .irq(irq),
    .next_frame_go(next_frame_go)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    bit match;
    bit [2:0] ev;
    bit [2:0] ak;
    if (!rst_n) begin
      m_fl = 0; m_en = 0; m_go = 0; m_f2 = 0; m_prev = 0;
    end else begin
      match = (line_cnt == line_thresh);
      ev = {ovf_err, match && !m_prev, cap_done};
      m_prev = match;
      ak = ctl_wr ? ctl_wdata[5:3] : 3'b000;
      for (int i = 0; i < 3; i++) begin
        if (ev[i]) m_fl[i] = 1;
        else if (ak[i]) m_fl[i] = 0;
      end
      m_go = ak[0];
      if (ctl_wr) m_en = ctl_wdata[2:0];
      if (vblank_start) m_f2 = field2_in;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    chk(cur_req, "stat_flags", int'(stat_flags), int'(m_fl));
    chk(cur_req, "irq", int'(irq), int'(|(m_fl & m_en)));
    chk(cur_req, "next_frame_go", int'(next_frame_go), int'(m_go));
    chk(cur_req, "stat_field2", int'(stat_field2), int'(m_f2));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] d);
    ctl_wr = 1'b1; ctl_wdata = d; tick(); ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  initial begin
    cur_req = "R1";
    tick(3);
    chk("R1", "irq in reset", int'(irq), 0);
    chk("R1", "flags in reset", int'(stat_flags), 0);
    rst_n = 1'b1;
    tick(2);

    cur_req = "R9";                         // enable all three
    wr(6'b000_111);
    tick();

    cur_req = "R2";
    cap_done = 1'b1; tick(); cap_done = 1'b0;
    chk("R2", "done flag", int'(stat_flags[0]), 1);
    chk("R8", "irq with done enabled", int'(irq), 1);
    ovf_err = 1'b1; tick(); ovf_err = 1'b0;
    chk("R2", "ovf flag", int'(stat_flags[2]), 1);

    cur_req = "R5";                         // acks written as 0
    wr(6'b000_111);
    chk("R5", "zero ack keeps flags", int'(stat_flags), 3'b101);
    wr(6'b101_111);                         // clear both at once
    chk("R5", "multi ack clears", int'(stat_flags), 0);
    chk("R8", "irq drops on clearing edge", int'(irq), 0);
    chk("R7", "go pulse after done ack", int'(next_frame_go), 1);
    tick();
    chk("R7", "go single cycle", int'(next_frame_go), 0);

    cur_req = "R4";                         // threshold with all enables off
    wr(6'b000_000);
    for (int l = 0; l < 5; l++) begin line_cnt = LW'(l); tick(); end
    line_cnt = 11'd5; tick();
    chk("R4", "threshold sets with enables off", int'(stat_flags[1]), 1);
    chk("R4", "irq stays low", int'(irq), 0);
    cur_req = "R3";
    wr(6'b010_000);                         // ack while still equal
    tick(3);
    chk("R3", "no re-set while equal", int'(stat_flags[1]), 0);
    line_cnt = 11'd6; tick();
    line_cnt = 11'd5; tick();
    chk("R3", "re-arm after leaving", int'(stat_flags[1]), 1);
    wr(6'b010_000);

    cur_req = "R6";
    cap_done = 1'b1; ctl_wr = 1'b1; ctl_wdata = 6'b001_001; tick();
    cap_done = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0;
    chk("R6", "event beats ack", int'(stat_flags[0]), 1);
    chk("R7", "go even when event wins", int'(next_frame_go), 1);

    cur_req = "R8";
    wr(6'b000_100);                         // only overflow enabled
    chk("R8", "disabled flag no irq", int'(irq), 0);
    ovf_err = 1'b1; tick(); ovf_err = 1'b0;
    chk("R8", "enabled flag irq", int'(irq), 1);
    wr(6'b100_100);
    chk("R8", "irq clears with last enabled", int'(irq), 0);

    cur_req = "R10";
    field2_in = 1'b1; tick(2);
    chk("R10", "field held without vblank", int'(stat_field2), 0);
    vblank_start = 1'b1; tick(); vblank_start = 1'b0;
    chk("R10", "field latched on vblank", int'(stat_field2), 1);
    field2_in = 1'b0; tick();
    chk("R10", "field held after vblank", int'(stat_field2), 1);

    cur_req = "R8";                         // random mix, compared every cycle
    line_thresh = 11'd3;
    for (int k = 0; k < 400; k++) begin
      cap_done     = ($urandom_range(0, 9) == 0);
      ovf_err      = ($urandom_range(0, 11) == 0);
      line_cnt     = LW'($urandom_range(0, 6));
      field2_in    = 1'($urandom_range(0, 1));
      vblank_start = ($urandom_range(0, 7) == 0);
      ctl_wr       = ($urandom_range(0, 4) == 0);
      ctl_wdata    = 6'($urandom_range(0, 63));
      tick();
    end
    cap_done = 0; ovf_err = 0; vblank_start = 0; ctl_wr = 0;
    tick(2);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule